// File: doc/BRIEF.md
# Clamp and Coast Window Generator

This block produces the two sync-referenced timing windows that a video digitizer front end needs around its sampling clock. The clamp window tells the analog input stage when to restore its black level. It opens a programmed number of pixel clocks after each horizontal sync pulse ends and stays open for a programmed number of pixel clocks. Where the board supplies its own clamp strobe, a select bit routes that pin to the output in place of the internal window, with a bit that sets which level of the pin counts as active.

The coast window tells the pixel clock recovery loop to hold its frequency while vertical sync disturbs the horizontal pulses. It closes a programmed number of line periods after the vertical sync leading edge. It should also open a programmed number of line periods before that edge. The edge cannot be seen in advance, so the block counts lines in each frame and uses the length of the previous frame to predict where the next edge falls. Until a whole frame has been measured, the window opens at the vertical edge itself. An external coast pin of selectable polarity can replace the internal window.

All logic runs in the pixel clock domain. The sync and strobe pins are each registered once before they are used.

Top module: `sync_window_gen`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `clamp_out` and `coast_out` are 0.
- R2: `hsync_in` is normalized by `cfg_hs_pol` (1 = pulse is high, 0 = pulse is low). The trailing edge is the change from the active level to the idle level. The leading edge is the change the other way.
- R3: With the internal clamp selected, `clamp_out` first reads 1 after the (`cfg_clamp_start`+2)-th rising clock edge that follows the trailing-edge change on `hsync_in`.
- R4: The internal clamp pulse lasts exactly `cfg_clamp_len` clocks. When `cfg_clamp_len` is 0, no pulse is produced.
- R5: A new HSYNC trailing edge that arrives while a clamp delay or pulse is in progress restarts the timing from that edge. The earlier edge then produces no pulse of its own.
- R6: With `cfg_clamp_ext_sel` = 1, `clamp_out` follows `ext_clamp_in` one clock later, with the pin active high when `cfg_clamp_ext_pol` = 1 and active low when it is 0. HSYNC edges have no effect on `clamp_out` in this mode.
- R7: Each HSYNC leading edge advances a line count. Each rising edge of `vsync_in` stores the count as the frame length and clears it to 0.
- R8: Once a frame length L is known and 0 < `cfg_pre_coast` < L, the internal coast window opens during the line in which the count reaches L - `cfg_pre_coast`. That is `cfg_pre_coast` lines before the line that carries the vertical edge.
- R9: Before two VSYNC rising edges have been seen since reset, `cfg_pre_coast` is ignored and the window opens at the VSYNC rising edge.
- R10: After a VSYNC rising edge, the window stays open until the `cfg_post_coast`-th following HSYNC leading edge. When `cfg_post_coast` is 0, the window closes at the VSYNC edge.
- R11: With `cfg_coast_ext_sel` = 1, `coast_out` follows `ext_coast_in` one clock later, active high when `cfg_coast_ext_pol` = 1 and active low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync, active high |
| ext_clamp_in | input | 1 | External clamp strobe |
| ext_coast_in | input | 1 | External coast strobe |
| cfg_hs_pol | input | 1 | HSYNC active level (1 = high) |
| cfg_clamp_ext_sel | input | 1 | 1 = use the external clamp pin |
| cfg_clamp_ext_pol | input | 1 | External clamp active level (1 = high) |
| cfg_clamp_start | input | CNT_W | Clamp delay in clocks after the HSYNC trailing edge |
| cfg_clamp_len | input | CNT_W | Clamp pulse width in clocks |
| cfg_coast_ext_sel | input | 1 | 1 = use the external coast pin |
| cfg_coast_ext_pol | input | 1 | External coast active level (1 = high) |
| cfg_pre_coast | input | CNT_W | Lines of coast before the VSYNC edge |
| cfg_post_coast | input | CNT_W | Lines of coast after the VSYNC edge |
| clamp_out | output | 1 | Clamp window |
| coast_out | output | 1 | Coast window |

## Verification
The hardest situation to reach is the predicted opening of the coast window. It depends on a frame length that only exists after two vertical edges, so the stimulus drives whole frames of fixed-length lines. It checks the window at the end of every line across the unmeasured first frame and the measured frames that follow, then changes the post count to zero and runs further frames. The clamp restart is reached by sending a second short HSYNC pulse inside a long clamp delay and checking that the pulse lines up with the second edge only.

// File: rtl/swg_pkg.sv
package swg_pkg;

    parameter int unsigned SWG_CNT_W  = 8;
    parameter int unsigned SWG_LINE_W = 11;

    typedef enum logic [1:0] {
        CLP_IDLE = 2'd0,
        CLP_WAIT = 2'd1,
        CLP_ON   = 2'd2
    } clamp_phase_e;

endpackage

// File: rtl/swg_sync_in.sv
// Registers one sync pin, folds its polarity and flags both edges.
module swg_sync_in (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lead,
    output logic trail
);
    typedef struct packed {
        logic act;
        logic prev;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.act  = pol ? pin : ~pin;
        s_d.prev = s_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lead  = s_q.act & ~s_q.prev;
    assign trail = ~s_q.act & s_q.prev;
endmodule

// File: rtl/swg_clamp_timer.sv
// Delay-then-width clamp timer, restarted by every trailing edge.
module swg_clamp_timer #(
    parameter int unsigned CNT_W = swg_pkg::SWG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trail,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] len,
    output logic             pulse
);
    import swg_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        clamp_phase_e     phase;
        logic [CNT_W-1:0] cnt;
        logic             on;
    } clamp_s;

    clamp_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.phase)
            CLP_WAIT: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - ONE;
                end else if (len == '0) begin
                    c_d.phase = CLP_IDLE;
                    c_d.on    = 1'b0;
                end else begin
                    c_d.phase = CLP_ON;
                    c_d.cnt   = len - ONE;
                    c_d.on    = 1'b1;
                end
            end
            CLP_ON: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - ONE;
                end else begin
                    c_d.phase = CLP_IDLE;
                    c_d.on    = 1'b0;
                end
            end
            default: begin
                c_d.phase = CLP_IDLE;
                c_d.on    = 1'b0;
            end
        endcase

        // A fresh trailing edge wins over whatever was in progress.
        if (trail) begin
            if (len == '0) begin
                c_d.phase = CLP_IDLE;
                c_d.cnt   = '0;
                c_d.on    = 1'b0;
            end else if (start == '0) begin
                c_d.phase = CLP_ON;
                c_d.cnt   = len - ONE;
                c_d.on    = 1'b1;
            end else begin
                c_d.phase = CLP_WAIT;
                c_d.cnt   = start - ONE;
                c_d.on    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{phase: CLP_IDLE, cnt: '0, on: 1'b0};
        else        c_q <= c_d;
    end

    assign pulse = c_q.on;
endmodule

// File: rtl/swg_coast_timer.sv
// Line counter, frame-length predictor and coast window.
module swg_coast_timer #(
    parameter int unsigned CNT_W  = swg_pkg::SWG_CNT_W,
    parameter int unsigned LINE_W = swg_pkg::SWG_LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_lead,
    input  logic             vs_lead,
    input  logic [CNT_W-1:0] pre,
    input  logic [CNT_W-1:0] post,
    output logic             window
);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
    localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
    localparam logic [LINE_W-1:0] LMAX  = '1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [LINE_W-1:0] flen;
        logic              seen;
        logic              valid;
        logic [CNT_W-1:0]  post_cnt;
        logic              win;
    } coast_s;

    coast_s k_d, k_q;
    logic [LINE_W-1:0] pre_l;
    logic              pre_hit;

    always_comb begin
        pre_l   = LINE_W'(pre);
        pre_hit = k_q.valid && (pre_l != '0) && (pre_l < k_q.flen)
                  && (k_q.line == (k_q.flen - pre_l));

        k_d = k_q;
        if (hs_lead && (k_q.line != LMAX)) k_d.line = k_q.line + ONE_L;

        if (vs_lead) begin
            k_d.line     = '0;
            k_d.flen     = k_q.line;
            k_d.seen     = 1'b1;
            k_d.valid    = k_q.seen;
            k_d.post_cnt = post;
            k_d.win      = (post != '0);
        end else if (k_q.post_cnt != '0) begin
            if (hs_lead) begin
                k_d.post_cnt = k_q.post_cnt - ONE_C;
                if (k_q.post_cnt == ONE_C) k_d.win = 1'b0;
            end
        end else if (pre_hit) begin
            k_d.win = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign window = k_q.win;
endmodule

// File: rtl/sync_window_gen.sv
module sync_window_gen #(
    parameter int unsigned CNT_W  = swg_pkg::SWG_CNT_W,
    parameter int unsigned LINE_W = swg_pkg::SWG_LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             ext_clamp_in,
    input  logic             ext_coast_in,
    input  logic             cfg_hs_pol,
    input  logic             cfg_clamp_ext_sel,
    input  logic             cfg_clamp_ext_pol,
    input  logic [CNT_W-1:0] cfg_clamp_start,
    input  logic [CNT_W-1:0] cfg_clamp_len,
    input  logic             cfg_coast_ext_sel,
    input  logic             cfg_coast_ext_pol,
    input  logic [CNT_W-1:0] cfg_pre_coast,
    input  logic [CNT_W-1:0] cfg_post_coast,
    output logic             clamp_out,
    output logic             coast_out
);
    typedef struct packed {
        logic clamp;
        logic coast;
    } ext_s;

    ext_s e_d, e_q;

    logic hs_lead, hs_trail;
    logic vs_lead, vs_trail_unused;
    logic clamp_int, coast_int;

    swg_sync_in u_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (hsync_in),
        .pol   (cfg_hs_pol),
        .lead  (hs_lead),
        .trail (hs_trail)
    );

    swg_sync_in u_vs (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (vsync_in),
        .pol   (1'b1),
        .lead  (vs_lead),
        .trail (vs_trail_unused)
    );

    swg_clamp_timer #(.CNT_W(CNT_W)) u_clamp (
        .clk   (clk),
        .rst_n (rst_n),
        .trail (hs_trail),
        .start (cfg_clamp_start),
        .len   (cfg_clamp_len),
        .pulse (clamp_int)
    );

    swg_coast_timer #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_coast (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_lead (hs_lead),
        .vs_lead (vs_lead),
        .pre     (cfg_pre_coast),
        .post    (cfg_post_coast),
        .window  (coast_int)
    );

    always_comb begin
        e_d       = e_q;
        e_d.clamp = cfg_clamp_ext_pol ? ext_clamp_in : ~ext_clamp_in;
        e_d.coast = cfg_coast_ext_pol ? ext_coast_in : ~ext_coast_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign clamp_out = cfg_clamp_ext_sel ? e_q.clamp : clamp_int;
    assign coast_out = cfg_coast_ext_sel ? e_q.coast : coast_int;

    logic unused_ok;
    assign unused_ok = vs_trail_unused;
endmodule

// File: rtl/swg_checker.sv
module swg_checker #(
    parameter int unsigned CNT_W = swg_pkg::SWG_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_trail,
    input logic             vs_lead,
    input logic             clamp_int,
    input logic             coast_int,
    input logic             ext_clamp_in,
    input logic             ext_coast_in,
    input logic             cfg_clamp_ext_sel,
    input logic             cfg_clamp_ext_pol,
    input logic             cfg_coast_ext_sel,
    input logic             cfg_coast_ext_pol,
    input logic [CNT_W-1:0] cfg_clamp_start,
    input logic [CNT_W-1:0] cfg_clamp_len,
    input logic [CNT_W-1:0] cfg_post_coast,
    input logic             clamp_out,
    input logic             coast_out
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!clamp_out && !coast_out));

    p_wait_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_trail && (cfg_clamp_start != '0) |=> !clamp_int);

    p_zero_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_trail && (cfg_clamp_start == '0) && (cfg_clamp_len != '0) |=> clamp_int);

    p_zero_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_trail && (cfg_clamp_len == '0) |=> !clamp_int);

    p_ext_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && cfg_clamp_ext_sel
        |-> (clamp_out == ($past(cfg_clamp_ext_pol) ? $past(ext_clamp_in) : !$past(ext_clamp_in))));

    p_open_at_vs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vs_lead && (cfg_post_coast != '0) |=> coast_int);

    p_close_at_vs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vs_lead && (cfg_post_coast == '0) |=> !coast_int);

    p_ext_coast_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && cfg_coast_ext_sel
        |-> (coast_out == ($past(cfg_coast_ext_pol) ? $past(ext_coast_in) : !$past(ext_coast_in))));
endmodule

bind sync_window_gen swg_checker #(.CNT_W(CNT_W)) u_swg_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .hs_trail          (hs_trail),
    .vs_lead           (vs_lead),
    .clamp_int         (clamp_int),
    .coast_int         (coast_int),
    .ext_clamp_in      (ext_clamp_in),
    .ext_coast_in      (ext_coast_in),
    .cfg_clamp_ext_sel (cfg_clamp_ext_sel),
    .cfg_clamp_ext_pol (cfg_clamp_ext_pol),
    .cfg_coast_ext_sel (cfg_coast_ext_sel),
    .cfg_coast_ext_pol (cfg_coast_ext_pol),
    .cfg_clamp_start   (cfg_clamp_start),
    .cfg_clamp_len     (cfg_clamp_len),
    .cfg_post_coast    (cfg_post_coast),
    .clamp_out         (clamp_out),
    .coast_out         (coast_out)
);

// File: tb/sync_window_gen_bench.sv
`timescale 1ns/1ps
module sync_window_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       vsync_in = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic       ext_coast_in = 1'b0;
    logic       cfg_hs_pol = 1'b1;
    logic       cfg_clamp_ext_sel = 1'b0;
    logic       cfg_clamp_ext_pol = 1'b1;
    logic [7:0] cfg_clamp_start = 8'd0;
    logic [7:0] cfg_clamp_len = 8'd0;
    logic       cfg_coast_ext_sel = 1'b0;
    logic       cfg_coast_ext_pol = 1'b1;
    logic [7:0] cfg_pre_coast = 8'd0;
    logic [7:0] cfg_post_coast = 8'd0;
    logic       clamp_out, coast_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sync_window_gen u_sync_window_gen (.*);

    typedef struct packed {
        logic [7:0] start;
        logic [7:0] len;
        logic       pol;
        logic [7:0] exp_first;
        logic [7:0] exp_width;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  8'd1,  1'b1, 8'd2,  8'd1},
        '{8'd2,  8'd3,  1'b1, 8'd4,  8'd3},
        '{8'd5,  8'd8,  1'b0, 8'd7,  8'd8},
        '{8'd13, 8'd2,  1'b0, 8'd15, 8'd2},
        '{8'd4,  8'd0,  1'b1, 8'd0,  8'd0},
        '{8'd30, 8'd20, 1'b1, 8'd32, 8'd20}
    };

    localparam int FRAME = 10;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One HSYNC pulse of 3 clocks, then 60 samples after the trailing change.
    task automatic clamp_pulse(output int first, output int width);
        hsync_in = cfg_hs_pol;
        idle(3);
        hsync_in = ~cfg_hs_pol;
        first = 0;
        width = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (clamp_out) begin
                if (first == 0) first = k;
                width++;
            end
        end
    endtask

    // One 16-clock line; returns coast_out sampled near its end.
    task automatic run_line(input bit vs, output bit smp);
        hsync_in = 1'b1;
        smp = 1'b0;
        for (int c = 1; c <= 16; c++) begin
            @(negedge clk);
            if (c == 2 && vs) vsync_in = 1'b1;
            if (c == 4) hsync_in = 1'b0;
            if (c == 10) vsync_in = 1'b0;
            if (c == 15) smp = coast_out;
        end
    endtask

    task automatic run_frames(input int f0, input int nf, input int pre, input int post);
        bit s;
        for (int f = f0; f < f0 + nf; f++) begin
            for (int k = 0; k < FRAME; k++) begin
                bit exp;
                string tag;
                run_line(k == 0, s);
                exp = (k < post) || (f >= 1 && pre > 0 && k >= FRAME - pre);
                if (f == 0) tag = "R9";
                else if (k >= FRAME - pre) tag = "R7 R8";
                else tag = "R10";
                chk($sformatf("%s coast frame %0d line %0d", tag, f, k), int'(s), int'(exp));
            end
        end
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int first, width;
        bit s;

        // R1: reset state
        idle(3);
        chk("R1 clamp in reset", int'(clamp_out), 0);
        chk("R1 coast in reset", int'(coast_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clamp after release", int'(clamp_out), 0);
        chk("R1 coast after release", int'(coast_out), 0);

        // R2 R3 R4: vector table walk
        for (int i = 0; i < NV; i++) begin
            cfg_clamp_start = VECS[i].start;
            cfg_clamp_len   = VECS[i].len;
            cfg_hs_pol      = VECS[i].pol;
            hsync_in        = ~VECS[i].pol;
            idle(60);
            clamp_pulse(first, width);
            chk($sformatf("R3 R2 first vec%0d", i), first, int'(VECS[i].exp_first));
            chk($sformatf("R4 width vec%0d", i), width, int'(VECS[i].exp_width));
        end

        // R5: second trailing edge inside the delay restarts it
        cfg_hs_pol = 1'b1;
        hsync_in = 1'b0;
        cfg_clamp_start = 8'd10;
        cfg_clamp_len = 8'd4;
        idle(60);
        hsync_in = 1'b1;
        idle(3);
        hsync_in = 1'b0;
        first = 0;
        width = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (clamp_out) begin
                if (first == 0) first = k;
                width++;
            end
            if (k == 3) hsync_in = 1'b1;
            if (k == 5) hsync_in = 1'b0;
        end
        chk("R5 restart first", first, 17);
        chk("R5 restart width", width, 4);

        // R6: external clamp, active low
        cfg_clamp_ext_sel = 1'b1;
        cfg_clamp_ext_pol = 1'b0;
        ext_clamp_in = 1'b1;
        idle(2);
        chk("R6 ext clamp idle", int'(clamp_out), 0);
        ext_clamp_in = 1'b0;
        @(negedge clk);
        chk("R6 ext clamp active low", int'(clamp_out), 1);
        ext_clamp_in = 1'b1;
        @(negedge clk);
        chk("R6 ext clamp released", int'(clamp_out), 0);
        clamp_pulse(first, width);
        chk("R6 hsync ignored in ext mode", width, 0);
        cfg_clamp_ext_pol = 1'b1;
        ext_clamp_in = 1'b1;
        @(negedge clk);
        chk("R6 ext clamp active high", int'(clamp_out), 1);
        ext_clamp_in = 1'b0;
        cfg_clamp_ext_sel = 1'b0;
        cfg_clamp_len = 8'd0;
        idle(40);

        // R7 R8 R9 R10: whole frames
        cfg_pre_coast = 8'd3;
        cfg_post_coast = 8'd2;
        run_frames(0, 4, 3, 2);
        cfg_pre_coast = 8'd2;
        cfg_post_coast = 8'd0;
        run_frames(4, 2, 2, 0);

        // R11: external coast
        cfg_coast_ext_sel = 1'b1;
        cfg_coast_ext_pol = 1'b0;
        ext_coast_in = 1'b1;
        idle(2);
        chk("R11 ext coast idle", int'(coast_out), 0);
        ext_coast_in = 1'b0;
        @(negedge clk);
        chk("R11 ext coast active low", int'(coast_out), 1);
        cfg_coast_ext_pol = 1'b1;
        ext_coast_in = 1'b1;
        @(negedge clk);
        chk("R11 ext coast active high", int'(coast_out), 1);
        ext_coast_in = 1'b0;
        @(negedge clk);
        chk("R11 ext coast released", int'(coast_out), 0);
        run_line(1'b0, s);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule